// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer with a single 8-bit control register. Software enables the watchdog, picks one of eight timeout lengths and must pulse a kick input often enough to keep a counter from running out. If the counter reaches the selected length while the watchdog is on, the block drives a one-cycle system reset pulse and starts counting again. The counter advances only on cycles where the tick input is high, so the time base comes from outside the block.

Two static strap inputs choose a protection level. The level sets whether the watchdog comes out of reset running and which register changes need a guarded two-step write. In that sequence, a first write sets the unlock bit. For exactly four clock cycles after that, a guarded change (turning the watchdog off, or loading a new timeout select) is allowed. When the window closes, the unlock bit clears itself.

Top module: `guarded_wdt`

## Requirements
- R1: The register reads as {3'b000, unlock (bit 4), enable (bit 3), timeout select (bits 2..0)}. Bits 7..5 read as zero whatever was written to them.
- R2: Straps (compat=0, always_on=0) select level 1, (compat=1, always_on=0) select level 0, and always_on=1 selects level 2 whatever compat is. After reset the register reads 0x08 in level 2 and 0x00 in levels 0 and 1.
- R3: A write with bit 4 set makes the unlock bit read one for exactly four cycles after that write, and then zero. A later write with bit 4 set restarts the window. A write with bit 4 clear does not shorten it.
- R4: In levels 0 and 1, a write with bit 3 set turns the watchdog on whatever the unlock state.
- R5: In levels 0 and 1, a write with bit 3 clear turns the watchdog off only if the unlock bit read one before that write. Otherwise enable keeps its value.
- R6: In level 2 the enable bit always reads one, and no write or sequence turns the watchdog off.
- R7: In levels 1 and 2, a write loads bits 2..0 into the timeout select only if the unlock bit read one before that write. Otherwise the select keeps its value.
- R8: In level 0, every write loads bits 2..0 into the timeout select with no unlock needed.
- R9: While enabled with select N, the reset output goes high for one cycle after 2^(BASE_EXP+N) tick cycles counted since the last clear, and the count restarts from zero.
- R10: A kick clears the counter, so a full timeout period must pass after the kick before the next reset pulse.
- R11: While disabled, the counter stays at zero and no reset pulse is produced. After enabling, the first pulse comes a full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_compat_i | input | 1 | Static compatibility strap |
| cfg_always_on_i | input | 1 | Static always-on strap |
| reg_wr_i | input | 1 | Register write strobe, one cycle per write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_o | output | 8 | Register read data |
| kick_i | input | 1 | Watchdog service pulse; clears the counter |
| tick_i | input | 1 | Counter advance qualifier |
| sys_rst_o | output | 1 | One-cycle system reset request on timeout |

## Verification
The hardest case to reach from the ports is the boundary of the unlock window. A guarded write must land inside the four cycles or just after them, and the only sign of which one happened is the enable and select fields read back afterwards. Each bench task issues the unlock write and then places the guarded write back to back, or after exactly four idle cycles, counting falling edges from the unlock write. The reset pulse is timed the same way. A small BASE_EXP makes periods short enough that the bench can count every tick from the enabling write and require the pulse on one exact cycle.

// File: rtl/gwd_pkg.sv
package gwd_pkg;

   // register geometry; positions are what software decodes
   localparam int unsigned REG_W    = 8;
   localparam int unsigned UNLK_BIT = 4;
   localparam int unsigned ENA_BIT  = 3;
   localparam int unsigned SEL_LSB  = 0;

   typedef enum logic [1:0] {
      LVL_OPEN   = 2'd0,
      LVL_GUARD  = 2'd1,
      LVL_LOCKED = 2'd2
   } gwd_level_e;

   function automatic gwd_level_e level_of(input logic compat, input logic always_on);
      gwd_level_e lv;
      if (always_on)   lv = LVL_LOCKED;
      else if (compat) lv = LVL_OPEN;
      else             lv = LVL_GUARD;
      return lv;
   endfunction

endpackage

// File: rtl/gwd_level_dec.sv
module gwd_level_dec
   import gwd_pkg::*;
(
   input  logic       cfg_compat_i,
   input  logic       cfg_always_on_i,
   output gwd_level_e level_o,
   output logic       sel_guard_o,
   output logic       ena_locked_o
);

   always_comb begin
      level_o      = level_of(cfg_compat_i, cfg_always_on_i);
      sel_guard_o  = (level_o != LVL_OPEN);
      ena_locked_o = (level_o == LVL_LOCKED);
   end

endmodule

// File: rtl/gwd_ctrl_reg.sv
module gwd_ctrl_reg #(
   parameter int unsigned SEL_W  = 3,
   parameter int unsigned WINDOW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_guard_i,
   input  logic             ena_locked_i,
   input  logic             wr_i,
   input  logic             wr_unlk_i,
   input  logic             wr_ena_i,
   input  logic [SEL_W-1:0] wr_sel_i,
   output logic             unlk_o,
   output logic             ena_o,
   output logic [SEL_W-1:0] sel_o
);

   localparam int unsigned WIN_W = $clog2(WINDOW + 1);

   logic [WIN_W-1:0] win_q;
   logic             ena_q;
   logic [SEL_W-1:0] sel_q;
   logic             unlk_now;

   assign unlk_now = (win_q != '0);

   // unlock window: loaded by a write with the unlock bit, counts down to zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                win_q <= '0;
      else if (wr_i && wr_unlk_i) win_q <= WIN_W'(WINDOW);
      else if (unlk_now)         win_q <= win_q - WIN_W'(1);
   end

   // enable: set freely, cleared only inside the window, pinned when locked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ena_q <= ena_locked_i;
      else if (ena_locked_i) ena_q <= 1'b1;
      else if (wr_i) begin
         if (wr_ena_i)      ena_q <= 1'b1;
         else if (unlk_now) ena_q <= 1'b0;
      end
   end

   // timeout select: guarded unless the open level is active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 sel_q <= '0;
      else if (wr_i && (!sel_guard_i || unlk_now)) sel_q <= wr_sel_i;
   end

   assign unlk_o = unlk_now;
   assign ena_o  = ena_q;
   assign sel_o  = sel_q;

endmodule

// File: rtl/gwd_timeout.sv
module gwd_timeout #(
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned SEL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ena_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             tick_i,
   input  logic             kick_i,
   output logic             fire_o
);

   localparam int unsigned N_SEL = 1 << SEL_W;
   localparam int unsigned CNT_W = BASE_EXP + N_SEL - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [N_SEL-1:0] at_end;
   logic             hit;
   logic             fire_q;

   // one terminal comparator per selectable period
   for (genvar i = 0; i < N_SEL; i++) begin : g_term
      localparam int unsigned SH = BASE_EXP + i;
      localparam logic [CNT_W:0] LIM = (CNT_W + 1)'(1) << SH;
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIM - (CNT_W + 1)'(1));
      assign at_end[i] = (cnt_q >= LAST);
   end

   assign hit = at_end[sel_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (!ena_i || kick_i) begin
         cnt_q  <= '0;
         fire_q <= 1'b0;
      end else if (tick_i) begin
         if (hit) begin
            cnt_q  <= '0;
            fire_q <= 1'b1;
         end else begin
            cnt_q  <= cnt_q + CNT_W'(1);
            fire_q <= 1'b0;
         end
      end else begin
         fire_q <= 1'b0;
      end
   end

   assign fire_o = fire_q;

endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt
   import gwd_pkg::*;
#(
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned SEL_W    = 3,
   parameter int unsigned WINDOW   = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cfg_compat_i,
   input  logic       cfg_always_on_i,
   input  logic       reg_wr_i,
   input  logic [7:0] reg_wdata_i,
   output logic [7:0] reg_rd_o,
   input  logic       kick_i,
   input  logic       tick_i,
   output logic       sys_rst_o
);

   localparam int unsigned RSV_W = REG_W - UNLK_BIT - 1;

   if (BASE_EXP < 1) begin : g_bad_base
      $error("guarded_wdt: BASE_EXP must be at least 1");
   end
   if (WINDOW < 1) begin : g_bad_window
      $error("guarded_wdt: WINDOW must be at least 1");
   end
   if (SEL_W + SEL_LSB > ENA_BIT) begin : g_bad_sel
      $error("guarded_wdt: SEL_W does not fit below the enable bit");
   end

   gwd_level_e       level;
   logic             sel_guard;
   logic             ena_locked;
   logic             unlk;
   logic             ena;
   logic [SEL_W-1:0] sel;
   logic             rsv_unused;

   assign rsv_unused = ^reg_wdata_i[REG_W-1:UNLK_BIT+1];

   gwd_level_dec u_level (
      .cfg_compat_i    (cfg_compat_i),
      .cfg_always_on_i (cfg_always_on_i),
      .level_o         (level),
      .sel_guard_o     (sel_guard),
      .ena_locked_o    (ena_locked)
   );

   gwd_ctrl_reg #(
      .SEL_W  (SEL_W),
      .WINDOW (WINDOW)
   ) u_reg (
      .clk          (clk),
      .rst_n        (rst_n),
      .sel_guard_i  (sel_guard),
      .ena_locked_i (ena_locked),
      .wr_i         (reg_wr_i),
      .wr_unlk_i    (reg_wdata_i[UNLK_BIT]),
      .wr_ena_i     (reg_wdata_i[ENA_BIT]),
      .wr_sel_i     (reg_wdata_i[SEL_LSB +: SEL_W]),
      .unlk_o       (unlk),
      .ena_o        (ena),
      .sel_o        (sel)
   );

   gwd_timeout #(
      .BASE_EXP (BASE_EXP),
      .SEL_W    (SEL_W)
   ) u_tmo (
      .clk    (clk),
      .rst_n  (rst_n),
      .ena_i  (ena),
      .sel_i  (sel),
      .tick_i (tick_i),
      .kick_i (kick_i),
      .fire_o (sys_rst_o)
   );

   always_comb begin
      reg_rd_o = '0;
      reg_rd_o[REG_W-1 -: RSV_W]     = '0;
      reg_rd_o[UNLK_BIT]             = unlk;
      reg_rd_o[ENA_BIT]              = ena;
      reg_rd_o[SEL_LSB +: SEL_W]     = sel;
   end

endmodule

// File: rtl/gwd_checker.sv
module gwd_checker #(
   parameter int unsigned WINDOW = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_compat_i,
   input logic       cfg_always_on_i,
   input logic       reg_wr_i,
   input logic [7:0] reg_wdata_i,
   input logic [7:0] reg_rd_o,
   input logic       kick_i,
   input logic       sys_rst_o
);

   localparam int unsigned MW = $clog2(WINDOW + 1);

   logic [MW-1:0] win_model;
   logic          guarded_sel;

   assign guarded_sel = cfg_always_on_i || !cfg_compat_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              win_model <= '0;
      else if (reg_wr_i && reg_wdata_i[4])      win_model <= MW'(WINDOW);
      else if (win_model != '0)                 win_model <= win_model - MW'(1);
   end

   p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o[7:5] == 3'b000);

   p_unlock_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_o[4] == (win_model != '0));

   p_enable_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_i && reg_wdata_i[3]) |=> reg_rd_o[3]);

   p_no_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_o[3] && !reg_rd_o[4]) |=> reg_rd_o[3]);

   p_locked_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_always_on_i |-> reg_rd_o[3]);

   p_sel_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (guarded_sel && !reg_rd_o[4]) |=> $stable(reg_rd_o[2:0]));

   p_sel_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!guarded_sel && reg_wr_i) |=> (reg_rd_o[2:0] == $past(reg_wdata_i[2:0])));

   p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |=> !sys_rst_o);

   p_kick_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      kick_i |=> !sys_rst_o);

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd_o[3] |=> !sys_rst_o);

endmodule

bind guarded_wdt gwd_checker #(.WINDOW(WINDOW)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cfg_compat_i    (cfg_compat_i),
   .cfg_always_on_i (cfg_always_on_i),
   .reg_wr_i        (reg_wr_i),
   .reg_wdata_i     (reg_wdata_i),
   .reg_rd_o        (reg_rd_o),
   .kick_i          (kick_i),
   .sys_rst_o       (sys_rst_o)
);

// File: tb/guarded_wdt_tb_top.sv
`timescale 1ns/1ps
module guarded_wdt_tb_top;

   localparam int unsigned BASE_EXP = 3;
   localparam int unsigned P0 = 1 << BASE_EXP;
   localparam int unsigned P1 = 2 << BASE_EXP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       compat = 1'b0;
   logic       aon = 1'b0;
   logic       wr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rd;
   logic       kick = 1'b0;
   logic       tick = 1'b0;
   logic       srst;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   guarded_wdt #(.BASE_EXP(BASE_EXP), .SEL_W(3), .WINDOW(4)) dut_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .cfg_compat_i    (compat),
      .cfg_always_on_i (aon),
      .reg_wr_i        (wr),
      .reg_wdata_i     (wdata),
      .reg_rd_o        (rd),
      .kick_i          (kick),
      .tick_i          (tick),
      .sys_rst_o       (srst)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic do_reset(input logic c, input logic a);
      @(negedge clk);
      rst_n = 1'b0; compat = c; aon = a;
      wr = 1'b0; wdata = '0; kick = 1'b0; tick = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // write lands on the next rising edge; returns at the falling edge after it
   task automatic wr_reg(input logic [7:0] d);
      wr = 1'b1; wdata = d;
      @(negedge clk);
      wr = 1'b0; wdata = '0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset_levels;
      do_reset(1'b0, 1'b0); check("R2 level1 reset", rd, 8'h00);
      check("R9 no pulse at reset", srst, 1'b0);
      do_reset(1'b1, 1'b0); check("R2 level0 reset", rd, 8'h00);
      do_reset(1'b0, 1'b1); check("R2 level2 reset", rd, 8'h08);
      do_reset(1'b1, 1'b1); check("R2 level2 alt reset", rd, 8'h08);
   endtask

   task automatic t_layout;
      do_reset(1'b1, 1'b0);
      wr_reg(8'hE5); check("R1 reserved bits read zero", rd, 8'h05);
   endtask

   task automatic t_unlock_window;
      do_reset(1'b0, 1'b0);
      wr_reg(8'h10); check("R3 unlock visible", rd[4], 1'b1);
      for (int k = 1; k <= 4; k++) begin
         idle(1); check("R3 unlock window length", rd[4], (k < 4));
      end
      wr_reg(8'h10); wr_reg(8'h00);
      check("R3 zero write keeps unlock", rd[4], 1'b1);
      idle(2); check("R3 window not shortened", rd[4], 1'b1);
      idle(1); check("R3 window closes", rd[4], 1'b0);
   endtask

   task automatic t_enable_disable;
      do_reset(1'b0, 1'b0);
      wr_reg(8'h08); check("R4 enable without unlock", rd, 8'h08);
      wr_reg(8'h00); check("R5 disable ignored", rd, 8'h08);
      wr_reg(8'h18); idle(4); check("R3 unlock expired", rd, 8'h08);
      wr_reg(8'h00); check("R5 late disable ignored", rd, 8'h08);
      wr_reg(8'h18); wr_reg(8'h00); check("R5 disable inside window", rd, 8'h10);
      idle(4); check("R5 stays disabled", rd, 8'h00);
      do_reset(1'b1, 1'b0);
      wr_reg(8'h08); wr_reg(8'h00); check("R5 level0 disable ignored", rd, 8'h08);
   endtask

   task automatic t_locked;
      do_reset(1'b0, 1'b1);
      wr_reg(8'h00); check("R6 write zero keeps enable", rd, 8'h08);
      wr_reg(8'h18); wr_reg(8'h00); check("R6 sequence keeps enable", rd, 8'h18);
      do_reset(1'b1, 1'b1);
      wr_reg(8'h10); wr_reg(8'h00); check("R6 alt level keeps enable", rd, 8'h18);
   endtask

   task automatic t_sel_guard;
      do_reset(1'b0, 1'b0);
      wr_reg(8'h05); check("R7 select ignored without unlock", rd, 8'h00);
      wr_reg(8'h10); wr_reg(8'h05); check("R7 select loaded in window", rd, 8'h15);
      idle(4); wr_reg(8'h02); check("R7 select ignored after window", rd, 8'h05);
      do_reset(1'b0, 1'b1);
      wr_reg(8'h03); check("R7 level2 select ignored", rd, 8'h08);
      wr_reg(8'h18); wr_reg(8'h03); check("R7 level2 select loaded", rd, 8'h1B);
   endtask

   task automatic t_sel_free;
      do_reset(1'b1, 1'b0);
      wr_reg(8'h05); check("R8 free select 5", rd, 8'h05);
      wr_reg(8'h02); check("R8 free select 2", rd, 8'h02);
      wr_reg(8'h0B); check("R8 select with enable", rd, 8'h0B);
   endtask

   task automatic t_timeout;
      do_reset(1'b1, 1'b0);
      tick = 1'b1;
      wr_reg(8'h08);
      for (int k = 1; k <= 2 * P0; k++) begin
         idle(1); check("R9 period select 0", srst, (k == P0) || (k == 2 * P0));
      end
      do_reset(1'b1, 1'b0);
      tick = 1'b1;
      wr_reg(8'h09);
      for (int k = 1; k <= P1; k++) begin
         idle(1); check("R9 period select 1", srst, (k == P1));
      end
      do_reset(1'b0, 1'b1);
      tick = 1'b1;
      begin
         int pulses = 0;
         for (int k = 1; k <= 2 * P0 + 2; k++) begin
            idle(1); if (srst) pulses++;
         end
         check("R9 level2 runs from reset", pulses, 2);
      end
   endtask

   task automatic t_kick;
      do_reset(1'b1, 1'b0);
      tick = 1'b1;
      wr_reg(8'h08);
      for (int k = 1; k <= 6; k++) begin
         idle(1); check("R10 before kick", srst, 1'b0);
      end
      kick = 1'b1; idle(1); kick = 1'b0;
      check("R10 kick cycle", srst, 1'b0);
      for (int k = 8; k <= 7 + P0; k++) begin
         idle(1); check("R10 period after kick", srst, (k == 7 + P0));
      end
   endtask

   task automatic t_disabled;
      do_reset(1'b0, 1'b0);
      tick = 1'b1;
      begin
         int pulses = 0;
         for (int k = 0; k < 5 * P0; k++) begin
            idle(1); if (srst) pulses++;
         end
         check("R11 no pulse while disabled", pulses, 0);
      end
      wr_reg(8'h08);
      for (int k = 1; k <= P0; k++) begin
         idle(1); check("R11 full period after enable", srst, (k == P0));
      end
   endtask

   initial begin
      t_reset_levels();
      t_layout();
      t_unlock_window();
      t_enable_disable();
      t_locked();
      t_sel_guard();
      t_sel_free();
      t_timeout();
      t_kick();
      t_disabled();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule